// File: doc/BRIEF.md
# HS-Settle Count Calculator

This block turns a lane bit rate and an escape-clock frequency into the settle count that a high-speed serial receiver is programmed with. A single-cycle `start` pulse captures both rates and a mode bit. After that the block runs on its own copy of these values until the result is ready.

In formula mode the block first checks that the lane rate lies inside the legal band. It then works out the shortest and the longest allowed settle times in nanoseconds and takes their integer mean. It converts that mean into whole escape-clock periods and subtracts one. A single multi-cycle restoring divider serves every division in turn. In table mode the range check is the same, but the code comes from three fixed rate bands and the escape-clock rate plays no part.

The result is presented on `code`, `err` and `warn`, and a one-cycle `done` strobe marks it. The block carries no data stream, so every pin is plain control or status. A caller waits for `busy` to fall, or for `done`, before it issues the next request. The block has no back-pressure: it drops a `start` that arrives while `busy` is high.

Top module: `settle_calc`

## Requirements
- R1: A lane rate below 80,000,000 or above 1,500,000,000 sets `err`, drives `code` to 0 and clears `warn`. Both limits themselves are legal. The check applies in both modes.
- R2: Formula mode uses integer arithmetic throughout. kbps = lane/1000. The minimum is 85 + 6,000,000/kbps. The maximum is 140 + 10,000,000/kbps. The target is (minimum + maximum)/2, rounded down.
- R3: Formula mode computes period = 1,000,000,000/esc_rate and q = target/period. The code is q − 1, with `err` and `warn` both 0, when that value fits in `code`.
- R4: In formula mode an escape rate of 0 sets `err`, drives `code` to 0 and is never used as a divisor.
- R5: Table mode (`use_table`=1) gives code 11 below 250,000,000, code 8 below 500,000,000 and code 6 otherwise. An escape rate of 0 causes no error in this mode.
- R6: `done` is high for exactly one cycle. In that cycle `code`, `err` and `warn` hold the new result, and they keep it until the next result.
- R7: `busy` goes high in the cycle after an accepted `start` and stays high until the result is ready. A `start` that arrives while `busy` is high is ignored, together with the inputs presented with it.
- R8: When q = 0, the code saturates at 0 and `warn` is set.
- R9: When q − 1 exceeds 2^CW − 1, the code saturates at 2^CW − 1 and `warn` is set. This also covers an escape rate above 1,000,000,000, where the period rounds to 0.
- R10: After reset, `busy`, `done`, `code`, `err` and `warn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that captures the rates and the mode |
| use_table | input | 1 | 1 selects table mode, 0 selects formula mode |
| lane_rate | input | DW | Lane bit rate in bit/s |
| esc_rate | input | DW | Escape-clock frequency in Hz |
| busy | output | 1 | High while a computation runs |
| done | output | 1 | One-cycle result strobe |
| code | output | CW | Settle count |
| err | output | 1 | Rate out of band, or escape rate of 0 in formula mode |
| warn | output | 1 | Code was saturated |

## Verification
Any fault in the shared divider or in the order of its steps shows up on `code` in the same `done` cycle. A sweep of lane rates across every escape rate exposes it at once, because each wrong quotient moves the target or the period. A fault in the state sequencing shows up on `done` or `busy` within a few cycles: the strobe can be missing, last longer than one cycle, or be late. A capture register that a mid-run `start` corrupts changes the result of that very run.

// File: rtl/settle_pkg.sv
package settle_pkg;
  localparam longint unsigned LANE_LO   = 64'd80_000_000;
  localparam longint unsigned LANE_HI   = 64'd1_500_000_000;
  localparam longint unsigned BAND_SLOW = 64'd250_000_000;
  localparam longint unsigned BAND_MID  = 64'd500_000_000;
  localparam int unsigned     SETTLE_BASE = 225; // 85 + 140 ns

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_KB, S_U6, S_U10, S_PER, S_Q, S_FIN
  } calc_st_t;
endpackage

// File: rtl/settle_div.sv
module settle_div #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [DW-1:0] quo
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW:0]   rem_q;
  logic [DW-1:0] quo_q, den_q, num_q;
  logic [CNTW-1:0] cnt_q;
  logic          run_q;
  logic [DW:0]   rem_sh;
  logic          fits;

  assign rem_sh = {rem_q[DW-1:0], quo_q[DW-1]};
  assign fits   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; num_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= num;
        num_q <= num;
        den_q <= den;
        cnt_q <= CNTW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
        quo_q <= {quo_q[DW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && den_q != '0) |->
      ({32'd0, quo_q} * {32'd0, den_q} <= {32'd0, num_q}) &&
      (({32'd0, quo_q} + 1) * {32'd0, den_q} > {32'd0, num_q})); // R2
endmodule

// File: rtl/settle_table.sv
module settle_table #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic [DW-1:0] lane,
  output logic [CW-1:0] tcode
);
  import settle_pkg::*;

  always_comb begin
    if (lane < DW'(BAND_SLOW))      tcode = CW'(11);
    else if (lane < DW'(BAND_MID))  tcode = CW'(8);
    else                            tcode = CW'(6);
  end
endmodule

// File: rtl/settle_calc.sv
module settle_calc #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          use_table,
  input  logic [DW-1:0] lane_rate,
  input  logic [DW-1:0] esc_rate,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] code,
  output logic          err,
  output logic          warn
);
  import settle_pkg::*;

  localparam logic [DW-1:0] CMAX   = DW'((64'd1 << CW) - 1);
  localparam logic [DW-1:0] K_KILO = DW'(1000);
  localparam logic [DW-1:0] K_U6   = DW'(6_000_000);
  localparam logic [DW-1:0] K_U10  = DW'(10_000_000);
  localparam logic [DW-1:0] K_NS   = DW'(1_000_000_000);

  calc_st_t      st_q;
  logic [DW-1:0] lr_q, er_q, kb_q, u6_q, u10_q;
  logic          tbl_q;
  logic          go_q;
  logic [DW-1:0] num_q, den_q;
  logic          dv_fin;
  logic [DW-1:0] dv_quo;
  logic [CW-1:0] tbl_code;
  logic          out_band;
  logic [DW-1:0] target;
  logic [DW-1:0] qm1;

  settle_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go_q), .num(num_q), .den(den_q),
    .fin(dv_fin), .quo(dv_quo)
  );

  settle_table #(.DW(DW), .CW(CW)) u_tbl (.lane(lr_q), .tcode(tbl_code));

  assign out_band = (lr_q < DW'(LANE_LO)) || (lr_q > DW'(LANE_HI));
  assign target   = (DW'(SETTLE_BASE) + u6_q + u10_q) >> 1;
  assign qm1      = dv_quo - 1'b1;
  assign busy     = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      lr_q <= '0; er_q <= '0; tbl_q <= 1'b0;
      kb_q <= '0; u6_q <= '0; u10_q <= '0;
      go_q <= 1'b0; num_q <= '0; den_q <= '0;
      done <= 1'b0; code <= '0; err <= 1'b0; warn <= 1'b0;
    end else begin
      go_q <= 1'b0;
      done <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          lr_q <= lane_rate; er_q <= esc_rate; tbl_q <= use_table;
          st_q <= S_CHK;
        end
        S_CHK: begin
          if (out_band || (!tbl_q && er_q == '0)) begin
            code <= '0; err <= 1'b1; warn <= 1'b0; st_q <= S_FIN;
          end else if (tbl_q) begin
            code <= tbl_code; err <= 1'b0; warn <= 1'b0; st_q <= S_FIN;
          end else begin
            go_q <= 1'b1; num_q <= lr_q; den_q <= K_KILO; st_q <= S_KB;
          end
        end
        S_KB: if (dv_fin) begin
          kb_q <= dv_quo;
          go_q <= 1'b1; num_q <= K_U6; den_q <= dv_quo; st_q <= S_U6;
        end
        S_U6: if (dv_fin) begin
          u6_q <= dv_quo;
          go_q <= 1'b1; num_q <= K_U10; den_q <= kb_q; st_q <= S_U10;
        end
        S_U10: if (dv_fin) begin
          u10_q <= dv_quo;
          go_q <= 1'b1; num_q <= K_NS; den_q <= er_q; st_q <= S_PER;
        end
        S_PER: if (dv_fin) begin
          go_q <= 1'b1; num_q <= target; den_q <= dv_quo; st_q <= S_Q;
        end
        S_Q: if (dv_fin) begin
          err <= 1'b0;
          if (dv_quo == '0) begin
            code <= '0; warn <= 1'b1;
          end else if (qm1 > CMAX) begin
            code <= CW'(CMAX); warn <= 1'b1;
          end else begin
            code <= CW'(qm1); warn <= 1'b0;
          end
          st_q <= S_FIN;
        end
        S_FIN: begin
          done <= 1'b1;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && $past(st_q == S_IDLE)) |-> ($stable(code) && $stable(err) && $stable(warn))); // R6
  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (code == '0 && !warn)); // R1
  AST_BAND_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (lr_q >= DW'(LANE_LO) && lr_q <= DW'(LANE_HI))); // R1
  AST_ESC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tbl_q && er_q == '0) |-> err); // R4
  AST_TABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tbl_q && !err) |-> (code == CW'(11) || code == CW'(8) || code == CW'(6))); // R5
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lr_q) && $stable(er_q) && $stable(tbl_q))); // R7
endmodule

// File: tb/tb_settle_calc.sv
module tb_settle_calc;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam longint unsigned CMAXV = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic use_table = 1'b0;
  logic [DW-1:0] lane_rate = '0;
  logic [DW-1:0] esc_rate = '0;
  logic busy, done, err, warn;
  logic [CW-1:0] code;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  settle_calc #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_table(use_table),
    .lane_rate(lane_rate), .esc_rate(esc_rate), .busy(busy), .done(done),
    .code(code), .err(err), .warn(warn)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_res(input longint unsigned lr, input longint unsigned er,
                            input bit tbl, output longint unsigned ec,
                            output bit ee, output bit ew, output string tag);
    longint unsigned kb, u6, u10, tgt, per, q;
    ee = 0; ew = 0; ec = 0;
    if (lr < 80_000_000 || lr > 1_500_000_000) begin
      ee = 1; tag = "R1"; return;
    end
    if (tbl) begin
      tag = "R5";
      ec = (lr < 250_000_000) ? 11 : (lr < 500_000_000) ? 8 : 6;
      return;
    end
    if (er == 0) begin ee = 1; tag = "R4"; return; end
    kb  = lr / 1000;
    u6  = 6_000_000 / kb;
    u10 = 10_000_000 / kb;
    tgt = (85 + u6 + 140 + u10) / 2;
    per = 1_000_000_000 / er;
    q   = (per == 0) ? 64'hFFFF_FFFF : tgt / per;
    if (q == 0) begin ec = 0; ew = 1; tag = "R8"; end
    else if (q - 1 > CMAXV) begin ec = CMAXV; ew = 1; tag = "R9"; end
    else begin ec = q - 1; tag = "R3"; end
  endtask

  task automatic run(input longint unsigned lr, input longint unsigned er,
                     input bit tbl, input bit poke);
    longint unsigned ec;
    bit ee, ew;
    string tag;
    int wait_n;
    logic [CW-1:0] held;
    expect_res(lr, er, tbl, ec, ee, ew, tag);
    @(negedge clk);
    lane_rate = DW'(lr); esc_rate = DW'(er); use_table = tbl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin
      lane_rate = 32'd2_000_000_000; esc_rate = 32'd0; use_table = ~tbl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (done !== 1'b1 && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    if (wait_n >= 2000) begin
      chk(1'b0, "R6 done timeout", 0, 1);
      return;
    end
    chk(code == CW'(ec), {tag, " code"}, code, ec);
    chk(err == ee, {tag, " err"}, err, ee);
    chk(warn == ew, {tag, " warn"}, warn, ew);
    chk(busy == 1'b0, "R7 idle at done", busy, 0);
    held = code;
    @(negedge clk);
    chk(done == 1'b0 && code == held, "R6 pulse and hold", {done, code}, {1'b0, held});
  endtask

  initial begin
    longint unsigned escs [7] = '{0, 1_000_000, 27_000_000, 72_000_000,
                                  133_000_000, 1_000_000_000, 2_000_000_000};
    longint unsigned edges [9] = '{0, 79_999_999, 80_000_000, 249_999_999,
                                   250_000_000, 499_999_999, 500_000_000,
                                   1_500_000_000, 1_500_000_001};
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && code == 0 && err == 0 && warn == 0,
        "R10 reset", {busy, done, err, warn, code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R5 band edges in table mode, escape rate 0 must not error
    for (int i = 0; i < 9; i++) run(edges[i], 0, 1'b1, 1'b0);
    // R2 R3 R4 R8 R9 formula sweep over edges and a spread of rates
    for (int e = 0; e < 7; e++) begin
      for (int i = 0; i < 9; i++) run(edges[i], escs[e], 1'b0, 1'b0);
      for (int k = 0; k < 30; k++)
        run(80_000_000 + longint'(k) * 49_000_000, escs[e], 1'b0, (k % 5) == 0);
    end
    // R7 mid-run start in table mode
    run(300_000_000, 0, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 190_000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule